// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This unit sits beside an I2C byte engine and decides whether the byte (or pair of bytes) that follows a START selects this slave. The engine presents each received byte with a one-cycle strobe and a flag marking it as the first byte after a START or repeated START. The unit compares that byte with every enabled address source. These sources are the primary address, an inclusive range window, a second address, the general call address and the alert response address. A two-byte 10-bit address is also supported. The unit answers one clock later.

A match produces a one-cycle pulse. The byte engine uses this pulse to set its transfer-complete flag. At the same time the unit latches an addressed flag, a range flag, a general-call flag and the read/write direction. These latched flags stay set until the next START or STOP, or until software clears them. The engine also tells the unit about START and STOP conditions and about software clear requests.

Top module: `i2c_addr_match`

## Requirements
- R1: The primary 7-bit address is taken from bits 7:1 of `cfg_prim`, and bit 0 of `cfg_prim` is ignored. A first byte whose bits 7:1 equal that address raises `match_pls` for exactly the cycle after the strobe and sets `addressed`.
- R2: On a 7-bit match, `rw_dir` takes bit 0 of the matching byte. A value of 1 means the slave transmits (master reading) and 0 means the slave receives.
- R3: With `cfg_rng_en` set, a first byte whose address lies between `cfg_prim[7:1]` and `cfg_rng[7:1]` matches and sets `range_hit`. Both ends count, and either bound may be the lower one. With `cfg_rng_en` clear, an address in that window other than the primary one does not match.
- R4: Byte 0x00 is a general call. It matches only with `cfg_gc_en` set, and it sets `gcall` with `rw_dir` 0. Byte 0x01 is never a general call.
- R5: The second address in `cfg_sec[7:1]` matches only while `cfg_sec_en` is set.
- R6: The alert response address 7'b0001100 (bytes 0x18/0x19) matches only while `cfg_alert_en` is set.
- R7: With `cfg_ext_en` set, the 10-bit address is {`cfg_ext_hi`, `cfg_prim[7:1]`}. A first byte 11110, address bits 9:8, 0 produces no match on its own. It is followed by a non-first byte equal to address bits 7:0, which matches, and `rw_dir` is then 0.
- R8: With `cfg_ext_en` set, there is no 7-bit primary or range match. A header with R/W=1, wrong high bits, a wrong second byte, or a START between the two bytes gives no match.
- R9: `bus_start`, `bus_stop` and `clr_flags` each clear `addressed`, `range_hit`, `gcall` and `rw_dir` on the next edge. A match in the same cycle wins over a clear.
- R10: A byte with `byte_first` low never produces a 7-bit match.
- R11: A byte that matches nothing leaves `match_pls` low and every latched flag unchanged.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | START or repeated START seen (pulse) |
| bus_stop | input | 1 | STOP seen (pulse) |
| clr_flags | input | 1 | Software clear of the latched flags (pulse) |
| byte_vld | input | 1 | Received byte strobe |
| byte_first | input | 1 | The strobed byte is the first after a START |
| byte_dat | input | 8 | Received byte, bit 0 is R/W on an address byte |
| cfg_prim | input | 8 | Primary address in bits 7:1 |
| cfg_rng | input | 8 | Range bound address in bits 7:1 |
| cfg_sec | input | 8 | Second address in bits 7:1 |
| cfg_ext_hi | input | 3 | Upper bits of the 10-bit address |
| cfg_ext_en | input | 1 | 10-bit addressing select |
| cfg_rng_en | input | 1 | Range window enable |
| cfg_gc_en | input | 1 | General call enable |
| cfg_sec_en | input | 1 | Second address enable |
| cfg_alert_en | input | 1 | Alert response address enable |
| match_pls | output | 1 | One-cycle pulse on any match |
| addressed | output | 1 | Latched: addressed as slave |
| range_hit | output | 1 | Latched: matched through the range window |
| gcall | output | 1 | Latched: general call received |
| rw_dir | output | 1 | Latched direction, 1 = slave transmit |

## Verification
Any wrong comparator or enable gating shows up one cycle after the strobe, either as a missing `match_pls` or as a spurious one, together with a wrong `addressed` level. A wrong 10-bit sequencer state shows up one strobe later, when the low byte either matches without its header or fails to match after a correct header. Flag-clearing faults stay visible on `addressed` until the next START, STOP or software clear, so a lost clear appears one edge after the pulse that should have caused it.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   localparam logic [4:0] TENBIT_HDR = 5'b11110;

   typedef struct packed {
      logic prim;
      logic rng;
      logic sec;
      logic gc;
      logic alert;
      logic ext;
   } am_hits_t;

   typedef enum logic [0:0] {
      EXT_IDLE    = 1'b0,
      EXT_WAIT_LO = 1'b1
   } ext_st_t;

endpackage

// File: rtl/i2c_am_cmp7.sv
module i2c_am_cmp7 #(
   parameter int unsigned          ADDR_W     = 7,
   parameter logic [ADDR_W-1:0]    GC_ADDR    = '0,
   parameter logic [ADDR_W-1:0]    ALERT_ADDR = 7'h0C,
   localparam int unsigned         BYTE_W     = ADDR_W + 1
) (
   input  logic [BYTE_W-1:0] byte_dat,
   input  logic [BYTE_W-1:0] cfg_prim,
   input  logic [BYTE_W-1:0] cfg_sec,
   input  logic              prim_en,
   input  logic              sec_en,
   input  logic              alert_en,
   input  logic              gc_en,
   output logic              prim_hit,
   output logic              sec_hit,
   output logic              alert_hit,
   output logic              gc_hit
);

   localparam int unsigned N_SRC = 3;

   logic [ADDR_W-1:0] src_addr [N_SRC];
   logic [N_SRC-1:0]  src_en;
   logic [N_SRC-1:0]  src_hit;
   logic              unused_cfg_lsb;

   assign src_addr[0] = cfg_prim[BYTE_W-1:1];
   assign src_addr[1] = cfg_sec[BYTE_W-1:1];
   assign src_addr[2] = ALERT_ADDR;
   assign src_en      = {alert_en, sec_en, prim_en};

   for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
      assign src_hit[gi] = src_en[gi] && (byte_dat[BYTE_W-1:1] == src_addr[gi]);
   end

   assign prim_hit  = src_hit[0];
   assign sec_hit   = src_hit[1];
   assign alert_hit = src_hit[2];
   // general call is only valid with the write direction
   assign gc_hit    = gc_en && (byte_dat == {GC_ADDR, 1'b0});

   assign unused_cfg_lsb = cfg_prim[0] ^ cfg_sec[0];

endmodule

// File: rtl/i2c_am_range.sv
module i2c_am_range #(
   parameter int unsigned ADDR_W        = 7,
   parameter bit          RANGE_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] bound_a,
   input  logic [ADDR_W-1:0] bound_b,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   output logic              in_win
);

   if (RANGE_SUPPORT) begin : g_range
      logic [ADDR_W-1:0] lo, hi;
      always_comb begin
         if (bound_a <= bound_b) begin
            lo = bound_a;
            hi = bound_b;
         end else begin
            lo = bound_b;
            hi = bound_a;
         end
      end
      assign in_win = en && (addr >= lo) && (addr <= hi);
   end else begin : g_no_range
      logic unused_rng;
      assign unused_rng = ^{bound_a, bound_b, addr, en};
      assign in_win     = 1'b0;
   end

endmodule

// File: rtl/i2c_am_ext10.sv
module i2c_am_ext10
   import i2c_am_pkg::*;
#(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned EXT_W       = 3,
   parameter bit          EXT_SUPPORT = 1'b1,
   localparam int unsigned BYTE_W     = ADDR_W + 1,
   localparam int unsigned A10_W      = ADDR_W + EXT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_abort,
   input  logic              byte_vld,
   input  logic              byte_first,
   input  logic [BYTE_W-1:0] byte_dat,
   input  logic [ADDR_W-1:0] prim_addr,
   input  logic [EXT_W-1:0]  ext_hi,
   input  logic              ext_en,
   output logic              ext_hit
);

   if (EXT_SUPPORT) begin : g_ext
      logic [A10_W-1:0] addr10;
      logic [7:0]       hdr_byte;
      logic [7:0]       lo_byte;
      ext_st_t          st_q, st_d;
      logic             hdr_ok;

      assign addr10   = {ext_hi, prim_addr};
      assign hdr_byte = {TENBIT_HDR, addr10[9:8], 1'b0};
      assign lo_byte  = addr10[7:0];
      assign hdr_ok   = ext_en && (byte_dat == hdr_byte);

      always_comb begin
         st_d = st_q;
         if (byte_vld && byte_first) begin
            st_d = hdr_ok ? EXT_WAIT_LO : EXT_IDLE;
         end else if (byte_vld || seq_abort || !ext_en) begin
            st_d = EXT_IDLE;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= EXT_IDLE;
         else        st_q <= st_d;
      end

      assign ext_hit = byte_vld && !byte_first && ext_en &&
                       (st_q == EXT_WAIT_LO) && (byte_dat == lo_byte);
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ^{clk, rst_n, seq_abort, byte_vld, byte_first,
                            byte_dat, prim_addr, ext_hi, ext_en};
      assign ext_hit    = 1'b0;
   end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2c_am_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 7,
   parameter int unsigned       EXT_W         = 3,
   parameter bit                EXT_SUPPORT   = 1'b1,
   parameter bit                RANGE_SUPPORT = 1'b1,
   parameter logic [ADDR_W-1:0] GC_ADDR       = '0,
   parameter logic [ADDR_W-1:0] ALERT_ADDR    = 7'h0C,
   localparam int unsigned      BYTE_W        = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              clr_flags,
   input  logic              byte_vld,
   input  logic              byte_first,
   input  logic [BYTE_W-1:0] byte_dat,
   input  logic [BYTE_W-1:0] cfg_prim,
   input  logic [BYTE_W-1:0] cfg_rng,
   input  logic [BYTE_W-1:0] cfg_sec,
   input  logic [EXT_W-1:0]  cfg_ext_hi,
   input  logic              cfg_ext_en,
   input  logic              cfg_rng_en,
   input  logic              cfg_gc_en,
   input  logic              cfg_sec_en,
   input  logic              cfg_alert_en,
   output logic              match_pls,
   output logic              addressed,
   output logic              range_hit,
   output logic              gcall,
   output logic              rw_dir
);

   if (ADDR_W != 7) begin : g_bad_addr_w
      $error("i2c_addr_match: ADDR_W must be 7");
   end
   if (EXT_SUPPORT && (ADDR_W + EXT_W != 10)) begin : g_bad_ext_w
      $error("i2c_addr_match: ADDR_W + EXT_W must be 10");
   end

   am_hits_t hits;
   logic     first_vld;
   logic     ext_mode;
   logic     any_hit;
   logic     clr_any;
   logic     prim_raw, sec_raw, alert_raw, gc_raw, win_raw, ext_raw;

   assign ext_mode  = EXT_SUPPORT && cfg_ext_en;
   assign first_vld = byte_vld && byte_first;
   assign clr_any   = bus_start || bus_stop || clr_flags;

   i2c_am_cmp7 #(
      .ADDR_W     (ADDR_W),
      .GC_ADDR    (GC_ADDR),
      .ALERT_ADDR (ALERT_ADDR)
   ) u_cmp7 (
      .byte_dat  (byte_dat),
      .cfg_prim  (cfg_prim),
      .cfg_sec   (cfg_sec),
      .prim_en   (!ext_mode),
      .sec_en    (cfg_sec_en),
      .alert_en  (cfg_alert_en),
      .gc_en     (cfg_gc_en),
      .prim_hit  (prim_raw),
      .sec_hit   (sec_raw),
      .alert_hit (alert_raw),
      .gc_hit    (gc_raw)
   );

   i2c_am_range #(
      .ADDR_W        (ADDR_W),
      .RANGE_SUPPORT (RANGE_SUPPORT)
   ) u_range (
      .bound_a (cfg_prim[BYTE_W-1:1]),
      .bound_b (cfg_rng[BYTE_W-1:1]),
      .addr    (byte_dat[BYTE_W-1:1]),
      .en      (cfg_rng_en && !ext_mode),
      .in_win  (win_raw)
   );

   i2c_am_ext10 #(
      .ADDR_W      (ADDR_W),
      .EXT_W       (EXT_W),
      .EXT_SUPPORT (EXT_SUPPORT)
   ) u_ext10 (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_abort  (bus_start || bus_stop),
      .byte_vld   (byte_vld),
      .byte_first (byte_first),
      .byte_dat   (byte_dat),
      .prim_addr  (cfg_prim[BYTE_W-1:1]),
      .ext_hi     (cfg_ext_hi),
      .ext_en     (cfg_ext_en),
      .ext_hit    (ext_raw)
   );

   always_comb begin
      hits.prim  = first_vld && prim_raw;
      hits.rng   = first_vld && win_raw;
      hits.sec   = first_vld && sec_raw;
      hits.gc    = first_vld && gc_raw;
      hits.alert = first_vld && alert_raw;
      hits.ext   = ext_raw;
   end

   assign any_hit = |hits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pls <= 1'b0;
         addressed <= 1'b0;
         range_hit <= 1'b0;
         gcall     <= 1'b0;
         rw_dir    <= 1'b0;
      end else begin
         match_pls <= any_hit;
         if (any_hit) begin
            addressed <= 1'b1;
            range_hit <= hits.rng;
            gcall     <= hits.gc;
            rw_dir    <= hits.ext ? 1'b0 : byte_dat[0];
         end else if (clr_any) begin
            addressed <= 1'b0;
            range_hit <= 1'b0;
            gcall     <= 1'b0;
            rw_dir    <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
   input logic clk,
   input logic rst_n,
   input logic bus_start,
   input logic bus_stop,
   input logic clr_flags,
   input logic byte_vld,
   input logic cfg_rng_en,
   input logic cfg_gc_en,
   input logic match_pls,
   input logic addressed,
   input logic range_hit,
   input logic gcall,
   input logic rw_dir
);

   AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      match_pls |-> $past(byte_vld)); // R1

   AST_PULSE_SETS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      match_pls |-> addressed); // R1

   AST_RANGE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      range_hit |-> addressed); // R3

   AST_RANGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(range_hit) |-> $past(cfg_rng_en)); // R3

   AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gcall) |-> $past(cfg_gc_en)); // R4

   AST_GC_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      gcall |-> !rw_dir); // R4

   AST_CLEAR_DROPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_start || bus_stop || clr_flags) && !byte_vld) |=> !addressed); // R9

   AST_NO_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && !bus_start && !bus_stop && !clr_flags) |=> $stable(addressed)); // R11

endmodule

bind i2c_addr_match i2c_am_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_start  (bus_start),
   .bus_stop   (bus_stop),
   .clr_flags  (clr_flags),
   .byte_vld   (byte_vld),
   .cfg_rng_en (cfg_rng_en),
   .cfg_gc_en  (cfg_gc_en),
   .match_pls  (match_pls),
   .addressed  (addressed),
   .range_hit  (range_hit),
   .gcall      (gcall),
   .rw_dir     (rw_dir)
);

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, clr_flags = 1'b0;
   logic       byte_vld = 1'b0, byte_first = 1'b0;
   logic [7:0] byte_dat = '0;
   logic [7:0] cfg_prim = '0, cfg_rng = '0, cfg_sec = '0;
   logic [2:0] cfg_ext_hi = '0;
   logic       cfg_ext_en = 1'b0, cfg_rng_en = 1'b0, cfg_gc_en = 1'b0;
   logic       cfg_sec_en = 1'b0, cfg_alert_en = 1'b0;
   logic       match_pls, addressed, range_hit, gcall, rw_dir;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   i2c_addr_match dut_i (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .clr_flags(clr_flags), .byte_vld(byte_vld), .byte_first(byte_first),
      .byte_dat(byte_dat), .cfg_prim(cfg_prim), .cfg_rng(cfg_rng),
      .cfg_sec(cfg_sec), .cfg_ext_hi(cfg_ext_hi), .cfg_ext_en(cfg_ext_en),
      .cfg_rng_en(cfg_rng_en), .cfg_gc_en(cfg_gc_en), .cfg_sec_en(cfg_sec_en),
      .cfg_alert_en(cfg_alert_en), .match_pls(match_pls), .addressed(addressed),
      .range_hit(range_hit), .gcall(gcall), .rw_dir(rw_dir)
   );

   // en = {rng, gc, sec, alert}; exp = {match, range, gcall, dir}
   typedef struct packed {
      logic [7:0] prim;
      logic [7:0] rng;
      logic [7:0] sec;
      logic [3:0] en;
      logic [7:0] dat;
      logic [3:0] exp;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h54, 4'b1000},  // R1 primary write
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h55, 4'b1001},  // R2 primary read
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h56, 4'b0000},  // R3 window, range off
      '{8'h54, 8'h60, 8'h90, 4'b1000, 8'h56, 4'b1100},  // R3 inside window
      '{8'h54, 8'h60, 8'h90, 4'b1000, 8'h60, 4'b1100},  // R3 upper bound
      '{8'h54, 8'h60, 8'h90, 4'b1000, 8'h62, 4'b0000},  // R3 above window
      '{8'h54, 8'h60, 8'h90, 4'b1000, 8'h52, 4'b0000},  // R3 below window
      '{8'h60, 8'h54, 8'h90, 4'b1000, 8'h59, 4'b1101},  // R3 swapped bounds
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h00, 4'b0000},  // R4 gc disabled
      '{8'h54, 8'h60, 8'h90, 4'b0100, 8'h00, 4'b1010},  // R4 gc enabled
      '{8'h54, 8'h60, 8'h90, 4'b0100, 8'h01, 4'b0000},  // R4 0x01 no gc
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h90, 4'b0000},  // R5 second disabled
      '{8'h54, 8'h60, 8'h90, 4'b0010, 8'h91, 4'b1001},  // R5 second enabled
      '{8'h54, 8'h60, 8'h90, 4'b0000, 8'h19, 4'b0000},  // R6 alert disabled
      '{8'h54, 8'h60, 8'h90, 4'b0001, 8'h19, 4'b1001},  // R6 alert enabled
      '{8'h55, 8'h60, 8'h90, 4'b0000, 8'h54, 4'b1000}   // R1 cfg bit 0 ignored
   };

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic chk_all(input logic [4:0] exp, input string req);
      chk(match_pls, exp[4], req, "match_pls");
      chk(addressed, exp[3], req, "addressed");
      chk(range_hit, exp[2], req, "range_hit");
      chk(gcall,     exp[1], req, "gcall");
      chk(rw_dir,    exp[0], req, "rw_dir");
   endtask

   task automatic send_byte(input logic [7:0] d, input logic first);
      byte_dat   = d;
      byte_first = first;
      byte_vld   = 1'b1;
      @(negedge clk);
      byte_vld   = 1'b0;
      byte_first = 1'b0;
   endtask

   task automatic pulse_start();
      bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_all(5'b00000, "R12");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all(5'b00000, "R12");

      for (int i = 0; i < NV; i++) begin
         cfg_prim     = VECS[i].prim;
         cfg_rng      = VECS[i].rng;
         cfg_sec      = VECS[i].sec;
         {cfg_rng_en, cfg_gc_en, cfg_sec_en, cfg_alert_en} = VECS[i].en;
         pulse_start();
         send_byte(VECS[i].dat, 1'b1);
         chk_all({VECS[i].exp[3], VECS[i].exp}, $sformatf("vector %0d", i));
      end

      // R11: unmatched first byte keeps flags
      cfg_prim = 8'h54; {cfg_rng_en, cfg_gc_en, cfg_sec_en, cfg_alert_en} = 4'b0000;
      pulse_start();
      send_byte(8'h55, 1'b1);
      send_byte(8'h70, 1'b1);
      chk_all(5'b01001, "R11");

      // R10: non-first byte does not match
      pulse_start();
      send_byte(8'h54, 1'b0);
      chk_all(5'b00000, "R10");

      // R9: stop, software clear, start each clear the flags
      send_byte(8'h55, 1'b1);
      bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
      chk_all(5'b00000, "R9 stop");
      send_byte(8'h55, 1'b1);
      clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
      chk_all(5'b00000, "R9 clr");
      send_byte(8'h55, 1'b1);
      pulse_start();
      chk_all(5'b00000, "R9 start");
      clr_flags = 1'b1;
      send_byte(8'h55, 1'b1);
      clr_flags = 1'b0;
      chk_all(5'b11001, "R9 same cycle");

      // R7: 10-bit address {101, 0101010}: header 0xF4, low byte 0xAA
      cfg_ext_en = 1'b1; cfg_ext_hi = 3'b101;
      pulse_start();
      send_byte(8'hF4, 1'b1);
      chk_all(5'b00000, "R7 header only");
      send_byte(8'hAA, 1'b0);
      chk_all(5'b11000, "R7 full match");

      // R8: 10-bit mode rejections
      pulse_start();
      send_byte(8'h54, 1'b1);
      chk_all(5'b00000, "R8 7-bit primary off");
      pulse_start();
      send_byte(8'hF5, 1'b1); send_byte(8'hAA, 1'b0);
      chk_all(5'b00000, "R8 header read");
      pulse_start();
      send_byte(8'hF2, 1'b1); send_byte(8'hAA, 1'b0);
      chk_all(5'b00000, "R8 wrong high bits");
      pulse_start();
      send_byte(8'hF4, 1'b1); send_byte(8'hAB, 1'b0);
      chk_all(5'b00000, "R8 wrong low byte");
      pulse_start();
      send_byte(8'hF4, 1'b1); pulse_start(); send_byte(8'hAA, 1'b0);
      chk_all(5'b00000, "R8 start aborts");
      cfg_ext_en = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule